// File: doc/BRIEF.md
# Keyboard Key-Change Handshake Receiver

This block takes key-change events from a keyboard controller at the far end of a short cable. The keyboard raises a request line when it has a change waiting. The receiver answers with an acknowledge. The keyboard then clocks in a nine-bit serial frame on its own bit strobe: eight data bits, least significant bit first, followed by a stop bit. All three keyboard lines are asynchronous, and each passes through a two-flop synchronizer.

A frame that ends with a good stop bit is split into a seven-bit key code and a make flag. The result is held in an output register and offered to the host on a valid/ready port. Back-pressure works through the acknowledge. While the register holds an unread event, the receiver withholds the acknowledge for a bounded number of cycles, so the keyboard keeps the change in its own queue. Once that bound runs out, the receiver acknowledges anyway, and the newer event replaces the older one with an overrun flag set. The interrupt line follows the unread state of the register. A frame whose stop bit is low is dropped and sets a framing-error flag.

Top module: `keylink_rx`

## Requirements
- R1: After reset, kb_ack, evt_valid, irq, frame_err and overrun are all 0.
- R2: kb_ack rises only while the synchronized kb_req is 1. It falls in the cycle after the stop bit is sampled. A further acknowledge needs kb_req to return to 0 first.
- R3: While kb_ack is high, each rising edge of kb_strobe samples kb_data. Samples 1 to 8 are data bits 0 to 7 (least significant first), and sample 9 is the stop bit.
- R4: evt_code carries data bits 6..0. evt_make carries data bit 7, where 1 means the key was pressed and 0 means it was released.
- R5: A frame with a stop bit of 1 loads the event and sets evt_valid. irq equals evt_valid and stays high until the event is read.
- R6: A frame with a stop bit of 0 sets frame_err. It leaves evt_valid, evt_code, evt_make and overrun unchanged. frame_err clears when the next acknowledge is given.
- R7: A read (evt_valid and evt_ready both 1 in one cycle) clears evt_valid, irq and overrun in the next cycle.
- R8: While an event is unread, a pending request gets no acknowledge for HOLD_CYC cycles. A read inside that window lets the acknowledge follow within a few cycles.
- R9: When the HOLD_CYC window expires, the request is acknowledged. If the frame completes while the previous event is still unread, overrun is set and the newer event overwrites the older one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kb_req | input | 1 | Keyboard change-pending request (asynchronous) |
| kb_strobe | input | 1 | Keyboard bit strobe; data is sampled on its rising edge (asynchronous) |
| kb_data | input | 1 | Keyboard serial data (asynchronous) |
| kb_ack | output | 1 | Acknowledge to the keyboard |
| evt_valid | output | 1 | Held event is unread |
| evt_ready | input | 1 | Host accepts the event |
| evt_code | output | 7 | Key code of the held event |
| evt_make | output | 1 | 1 = pressed, 0 = released |
| irq | output | 1 | Interrupt to the host, high while an event is unread |
| frame_err | output | 1 | Last frame had a low stop bit |
| overrun | output | 1 | An unread event was overwritten |

## Verification
The assertions assume a keyboard that keeps kb_req high until kb_ack has come and gone. The relation between a rising acknowledge and the request depends on that. They also assume the keyboard never strobes before the acknowledge. The bench drives the keyboard side only through task sequences with these properties. Each data level is held several clock cycles on both sides of its strobe edge, so the two synchronized lines always agree at the sampling point. Key bytes come from a seeded random stream. Directed frames cover the bit-order extremes, framing errors, the withheld acknowledge and overruns.

// File: rtl/keylink_pkg.sv
package keylink_pkg;
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_RECV    = 2'd1,
    LK_RELEASE = 2'd2
  } lk_state_e;
endpackage

// File: rtl/keylink_sync.sv
module keylink_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= din[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/keylink_shift.sv
module keylink_shift #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 strobe_s,
  input  logic                 data_s,
  output logic                 done,
  output logic                 stop_bit,
  output logic [DATA_BITS-1:0] byte_o
);
  localparam int CW = $clog2(DATA_BITS + 1);

  logic          strobe_q;
  logic [CW-1:0] cnt;
  logic          edge_s;

  assign edge_s   = strobe_s & ~strobe_q;
  assign done     = arm & edge_s & (cnt == CW'(DATA_BITS));
  assign stop_bit = data_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt      <= '0;
      byte_o   <= '0;
    end else begin
      strobe_q <= strobe_s;
      if (!arm) begin
        cnt <= '0;
      end else if (edge_s && cnt != CW'(DATA_BITS)) begin
        byte_o <= {data_s, byte_o[DATA_BITS-1:1]};
        cnt    <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/keylink_hold.sv
module keylink_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] din,
  input  logic                 rd,
  output logic                 valid,
  output logic [DATA_BITS-2:0] code,
  output logic                 make,
  output logic                 ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= '0;
      make  <= 1'b0;
      ovr   <= 1'b0;
    end else if (load) begin
      code  <= din[DATA_BITS-2:0];
      make  <= din[DATA_BITS-1];
      valid <= 1'b1;
      ovr   <= valid & ~rd;
    end else if (rd) begin
      valid <= 1'b0;
      ovr   <= 1'b0;
    end
  end
endmodule

// File: rtl/keylink_rx.sv
module keylink_rx
  import keylink_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int HOLD_CYC  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 kb_req,
  input  logic                 kb_strobe,
  input  logic                 kb_data,
  output logic                 kb_ack,
  output logic                 evt_valid,
  input  logic                 evt_ready,
  output logic [DATA_BITS-2:0] evt_code,
  output logic                 evt_make,
  output logic                 irq,
  output logic                 frame_err,
  output logic                 overrun
);
  localparam int WCW = $clog2(HOLD_CYC + 1);

  logic [2:0]           sync_q;
  logic                 req_s, strobe_s, data_s;
  logic                 frm_done, stop_bit;
  logic [DATA_BITS-1:0] frm_byte;
  logic                 rd;
  logic                 timed_out, gate_open;
  logic [WCW-1:0]       wait_cnt;
  lk_state_e            state;

  keylink_sync #(.W(3)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .din({kb_req, kb_strobe, kb_data}), .q(sync_q)
  );
  assign {req_s, strobe_s, data_s} = sync_q;

  keylink_shift #(.DATA_BITS(DATA_BITS)) shift_i (
    .clk(clk), .rst_n(rst_n), .arm(state == LK_RECV),
    .strobe_s(strobe_s), .data_s(data_s),
    .done(frm_done), .stop_bit(stop_bit), .byte_o(frm_byte)
  );

  assign rd = evt_valid & evt_ready;

  keylink_hold #(.DATA_BITS(DATA_BITS)) hold_i (
    .clk(clk), .rst_n(rst_n), .load(frm_done & stop_bit), .din(frm_byte),
    .rd(rd), .valid(evt_valid), .code(evt_code), .make(evt_make), .ovr(overrun)
  );

  assign irq       = evt_valid;
  assign timed_out = (wait_cnt == WCW'(HOLD_CYC));
  assign gate_open = ~evt_valid | timed_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LK_IDLE;
      kb_ack    <= 1'b0;
      frame_err <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      if (state == LK_IDLE && req_s && evt_valid && !timed_out)
        wait_cnt <= wait_cnt + 1'b1;
      else if (!(state == LK_IDLE && req_s && evt_valid))
        wait_cnt <= '0;
      unique case (state)
        LK_IDLE: if (req_s && gate_open) begin
          kb_ack    <= 1'b1;
          frame_err <= 1'b0;
          state     <= LK_RECV;
        end
        LK_RECV: if (frm_done) begin
          kb_ack <= 1'b0;
          if (!stop_bit) frame_err <= 1'b1;
          state <= LK_RELEASE;
        end
        LK_RELEASE: if (!req_s) state <= LK_IDLE;
        default: state <= LK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/keylink_rx_chk.sv
module keylink_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic kb_ack,
  input logic req_s,
  input logic done,
  input logic evt_valid,
  input logic evt_ready,
  input logic frame_err,
  input logic overrun
);
  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kb_ack) |-> $past(req_s));
  // R2
  ack_drop_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(kb_ack) |-> $past(done));
  // R6
  err_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !$rose(evt_valid));
  // R9
  ovr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> evt_valid);
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && !done) |=> !evt_valid);
endmodule

bind keylink_rx keylink_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .kb_ack(kb_ack), .req_s(req_s), .done(frm_done),
  .evt_valid(evt_valid), .evt_ready(evt_ready), .frame_err(frame_err),
  .overrun(overrun)
);

// File: tb/keylink_rx_tb_top.sv
module keylink_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_CYC   = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kb_req = 1'b0, kb_strobe = 1'b0, kb_data = 1'b0, evt_ready = 1'b0;
  logic kb_ack, evt_valid, evt_make, irq, frame_err, overrun;
  logic [6:0] evt_code;
  int checks = 0, fails = 0, cycles = 0;
  bit ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  keylink_rx #(.DATA_BITS(8), .HOLD_CYC(HOLD_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .kb_req(kb_req), .kb_strobe(kb_strobe),
    .kb_data(kb_data), .kb_ack(kb_ack), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_code(evt_code), .evt_make(evt_make),
    .irq(irq), .frame_err(frame_err), .overrun(overrun)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish (act %0d exp <150000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [6:0] exp_code(logic [7:0] b); return b[6:0]; endfunction
  function automatic logic exp_make(logic [7:0] b); return b[7]; endfunction

  task automatic check(bit c, string req, int act, int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic raise_req(int limit, output bit got);
    got = 0;
    kb_req = 1'b1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (kb_ack) begin got = 1; break; end
    end
  endtask

  task automatic shift_bits(logic [7:0] b, bit stop);
    for (int i = 0; i < 9; i++) begin
      kb_data = (i < 8) ? b[i] : stop;
      cyc(3); kb_strobe = 1'b1; cyc(3); kb_strobe = 1'b0;
    end
    cyc(4);
  endtask

  task automatic drop_req;
    kb_req = 1'b0; cyc(5);
  endtask

  task automatic send(logic [7:0] b, bit stop);
    bit got;
    raise_req(200, got);
    check(got, "R2 ack given", got, 1);
    shift_bits(b, stop);
    check(!kb_ack, "R2 ack dropped after stop", kb_ack, 0);
    drop_req();
  endtask

  task automatic host_read;
    evt_ready = 1'b1; @(negedge clk); evt_ready = 1'b0; @(negedge clk);
    check(!evt_valid && !irq && !overrun, "R7 read clears", {evt_valid, irq, overrun}, 0);
  endtask

  task automatic expect_evt(logic [7:0] b, string req);
    check(evt_valid && irq, {req, " R5 valid/irq"}, {evt_valid, irq}, 3);
    check(evt_code == exp_code(b), {req, " R4 code"}, evt_code, exp_code(b));
    check(evt_make == exp_make(b), {req, " R4 make"}, evt_make, exp_make(b));
  endtask

  initial begin
    logic [7:0] b, a;
    void'($urandom(32'h1c0ffee));
    cyc(3);
    // R1 reset state
    check(!kb_ack && !evt_valid && !irq && !frame_err && !overrun, "R1 reset",
          {kb_ack, evt_valid, irq, frame_err, overrun}, 0);
    rst_n = 1'b1; cyc(3);
    check(!kb_ack, "R2 no ack without request", kb_ack, 0);

    // R3 bit order extremes, R4 field split
    send(8'h01, 1); expect_evt(8'h01, "R3 lsb"); host_read();
    send(8'h80, 1); expect_evt(8'h80, "R3 msb"); host_read();
    send(8'hff, 1); expect_evt(8'hff, "R4 all ones"); host_read();

    // random stream, read after each (R5, R7)
    for (int n = 0; n < 24; n++) begin
      b = 8'($urandom);
      send(b, 1); expect_evt(b, "R5 random"); host_read();
    end

    // R6 framing error with an empty holder
    send(8'h5a, 0);
    check(frame_err && !evt_valid, "R6 bad stop", {frame_err, evt_valid}, 2);
    send(8'h33, 1);
    check(!frame_err, "R6 err cleared by next ack", frame_err, 0);
    expect_evt(8'h33, "R6 good after err");

    // R8 acknowledge withheld while unread, released by read
    begin
      bit got;
      raise_req(30, got);
      check(!got, "R8 ack withheld", got, 0);
      evt_ready = 1'b1; @(negedge clk); evt_ready = 1'b0;
      raise_req(8, got);
      check(got, "R8 ack after read", got, 1);
      b = 8'h9c; shift_bits(b, 1); drop_req();
      expect_evt(b, "R8 frame after read");
    end

    // R6 bad frame while unread leaves held event intact
    send(8'h11, 0);
    check(frame_err && !overrun, "R6 err keeps holder", {frame_err, overrun}, 2);
    expect_evt(8'h9c, "R6 held unchanged");

    // R9 overrun after timeout
    a = 8'($urandom);
    send(a, 1);
    check(overrun && !frame_err, "R9 overrun set", {overrun, frame_err}, 2);
    expect_evt(a, "R9 newer overwrites");
    host_read();

    // eight queued changes back to back
    for (int n = 0; n < 8; n++) begin
      b = 8'($urandom);
      send(b, 1); expect_evt(b, "R5 burst");
      check(!overrun, "R9 no overrun when read", overrun, 0);
      host_read();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule